// File: doc/BRIEF.md
# Stage-Sequenced Wrapping Counter with Toggle Storage

This block is the gate-level form of a tiny endless loop: add one to a 2-bit unsigned variable, then idle for exactly one cycle, and repeat. A small one-hot controller steps the loop. The controller has three D flip-flops: a run flag, an assign stage and a wait stage. Two toggle flip-flops hold the variable's bits. A ripple-carry chain forms the toggle enables for the increment. The chain is gated by the assign stage, so the variable moves only while that stage is hot.

The controller has three named states. BOOT is the all-zero power-up state. ASSIGN has the run flag and the assign flop set. WAIT has the run flag and the wait flop set. The transitions are BOOT to ASSIGN (start), ASSIGN to WAIT (after the add) and WAIT to ASSIGN (loop back). Every count value therefore stays on the output for two cycles. The block is used wherever a free-running, evenly paced 2-bit phase count is needed. Reset is synchronous and active high.

Top module: `loop_counter`

## Requirements
- R1: While `rst` is high at a rising edge, every flop clears, so `count_o` reads 0 and the controller sits in BOOT.
- R2: On the first edge after reset is released, the controller takes the start transition BOOT to ASSIGN and `count_o` stays 0.
- R3: After boot, the controller alternates ASSIGN, WAIT, ASSIGN, ... on every edge. Exactly one of the assign and wait flops is set, and BOOT is never re-entered without reset.
- R4: `count_o` changes only at an edge where the ASSIGN state was active. At an edge leaving WAIT or BOOT, it holds its value.
- R5: At each edge leaving ASSIGN, `count_o` increases by exactly one.
- R6: The value is 2-bit unsigned and wraps from 3 to 0 with no extra cycle.
- R7: Bit 0 toggles at every edge leaving ASSIGN. Bit 1 toggles at such an edge only when bit 0 was 1 before it.
- R8: Counting n as the number of rising edges since the last edge with reset high, `count_o` equals (n/2) mod 4 with integer division. The per-cycle output is therefore 0,0,1,1,2,2,3,3 and then repeats.
- R9: Asserting reset in the middle of a run returns `count_o` to 0, and after release the sequence of R8 starts again from n = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all flops |
| rst | input | 1 | Synchronous active-high reset to the all-zero state |
| count_o | output | VAL_W (2) | Current value of the looping variable |

## Verification
A controller in the wrong state shows up at the ports within two edges. If ASSIGN is skipped or repeated, `count_o` holds for three or more cycles or steps on two edges in a row. A wrong carry gate shows up at the first 1-to-2 or 3-to-0 step as a wrong value. The bench therefore compares the output against an edge-counting model on every cycle, across a dozen wraps and a reset taken mid-run. A fault is caught no later than the next step of the affected bit.

// File: rtl/loop_counter_pkg.sv
package loop_counter_pkg;

    localparam int STAGE_W = 3;

    // Bit order {run, assign, wait}: one D flop per bit.
    typedef enum logic [STAGE_W-1:0] {
        ST_BOOT   = 3'b000,
        ST_ASSIGN = 3'b110,
        ST_WAIT   = 3'b101
    } stage_e;

endpackage

// File: rtl/loop_seq.sv
module loop_seq
    import loop_counter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic assign_act,
    output logic wait_act
);

    stage_e stage_q;
    stage_e stage_d;

    always_comb begin
        stage_d = ST_BOOT;
        unique case (stage_q)
            ST_BOOT:   stage_d = ST_ASSIGN;
            ST_ASSIGN: stage_d = ST_WAIT;
            ST_WAIT:   stage_d = ST_ASSIGN;
            default:   stage_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= ST_BOOT;
        else     stage_q <= stage_d;
    end

    always_comb begin
        assign_act = stage_q[1];
        wait_act   = stage_q[0];
    end

    // R3: stage ordering after boot
    a_r3_assign_to_wait: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_ASSIGN) |=> (stage_q == ST_WAIT));
    a_r3_wait_to_assign: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_WAIT) |=> (stage_q == ST_ASSIGN));
    a_r2_boot_starts: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_BOOT) |=> (stage_q == ST_ASSIGN));
    a_r3_one_stage: assert property (@(posedge clk) disable iff (rst)
        $onehot0({assign_act, wait_act}));

endmodule

// File: rtl/carry_gate.sv
module carry_gate #(
    parameter int VAL_W = 2
) (
    input  logic             en,
    input  logic [VAL_W-1:0] q,
    output logic [VAL_W-1:0] tog
);

    assign tog[0] = en;

    generate
        for (genvar i = 1; i < VAL_W; i++) begin : g_chain
            assign tog[i] = tog[i-1] & q[i-1];
        end
    endgenerate

endmodule

// File: rtl/tflop_bit.sv
module tflop_bit (
    input  logic clk,
    input  logic rst,
    input  logic t,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)    q <= 1'b0;
        else if (t) q <= ~q;
    end

endmodule

// File: rtl/loop_counter.sv
module loop_counter #(
    parameter int VAL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic [VAL_W-1:0] count_o
);

    logic             assign_act;
    logic             wait_act;
    logic [VAL_W-1:0] tog;
    logic [VAL_W-1:0] val_q;

    loop_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .assign_act (assign_act),
        .wait_act   (wait_act)
    );

    carry_gate #(.VAL_W(VAL_W)) u_carry (
        .en  (assign_act),
        .q   (val_q),
        .tog (tog)
    );

    generate
        for (genvar b = 0; b < VAL_W; b++) begin : g_bits
            tflop_bit u_tff (
                .clk (clk),
                .rst (rst),
                .t   (tog[b]),
                .q   (val_q[b])
            );
        end
    endgenerate

    assign count_o = val_q;

    // R4: hold outside the assign stage
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !assign_act |=> $stable(count_o));
    // R5 / R6: single step with wrap
    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        assign_act |=> (count_o == VAL_W'($past(count_o) + 1'b1)));
    // R7: bit 0 always toggles in the assign stage
    a_r7_bit0: assert property (@(posedge clk) disable iff (rst)
        assign_act |=> (count_o[0] != $past(count_o[0])));
    // R3: the wait stage never touches the value
    a_r3_wait_quiet: assert property (@(posedge clk) disable iff (rst)
        wait_act |=> $stable(count_o));

endmodule

// File: tb/tb_loop_counter.sv
module tb_loop_counter;

    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    loop_counter #(.VAL_W(W)) dut (
        .clk     (clk),
        .rst     (rst),
        .count_o (cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Hold reset for a number of edges, checking the output reads 0.
    task automatic hold_reset(input int edges, input string req);
        @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < edges; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(cnt == 0, req, int'(cnt), 0);
        end
        rst = 1'b0;
    endtask

    // Behavioural model: n edges since reset release -> (n/2) mod 4.
    task automatic run(input int cycles);
        int n    = 0;
        int prev = 0;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            begin
                int  e    = (n / 2) % 4;
                bit  step = (n % 2 == 0);
                int  b0   = (prev & 1) ^ int'(step);
                int  b1   = ((prev >> 1) & 1) ^ int'(step && (prev & 1));
                chk(int'(cnt) == e, (n == 1) ? "R2" : "R8", int'(cnt), e);
                if (!step)
                    chk(int'(cnt) == prev, "R3/R4", int'(cnt), prev);
                else
                    chk(int'(cnt) == (prev + 1) % 4, (prev == 3) ? "R6" : "R5",
                        int'(cnt), (prev + 1) % 4);
                chk(int'(cnt[0]) == b0, "R7 bit0", int'(cnt[0]), b0);
                chk(int'(cnt[1]) == b1, "R7 bit1", int'(cnt[1]), b1);
                prev = int'(cnt);
            end
        end
    endtask

    initial begin
        hold_reset(3, "R1");
        run(100);
        hold_reset(2, "R9");   // mid-run, odd position
        run(37);
        hold_reset(1, "R9");
        run(50);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule